// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block is a combinational barrel shifter. It takes one data word and a shift amount and returns the word rotated, logically shifted or arithmetically shifted, to the left or to the right, in a single pass with no register stage. The amount is an unsigned index into the word, so it ranges from zero up to one less than the width.

Inside, the block has a single right-going shift network of log2(width) stages. A left operation reverses the bit order before the network and again after it. At each stage the vacated positions take wrapped-around bits (rotate), zeros (logical), or copies of the original sign bit (arithmetic right only). An ALU or address-generation path uses it by driving the select lines and reading the result in the same cycle.

Top module: `barrel_shift_unit`

## Requirements
- R1: With kind 00 (rotate) and direction 0 (left), output bit i equals input bit (i - amount) mod WIDTH.
- R2: With kind 00 and direction 1 (right), output bit i equals input bit (i + amount) mod WIDTH.
- R3: With kind 01 (logical) and direction 0, the input moves toward the MSB by the amount, and the low positions it leaves are zero.
- R4: With kind 01 and direction 1, the input moves toward the LSB by the amount, and the high positions it leaves are zero.
- R5: With kind 10 (arithmetic) and direction 1, the input moves toward the LSB, and every high position it leaves holds a copy of the input MSB.
- R6: With kind 10 and direction 0, the result equals the logical left shift, with zeros in the low positions.
- R7: Kind 11 gives exactly the logical-shift result in both directions.
- R8: An amount of 0 returns the input unchanged for every kind and direction.
- R9: The largest amount (WIDTH-1, 15 at the default width) is handled correctly in all six modes.
- R10: A right rotation by n (1 to WIDTH-1) equals a left rotation by WIDTH-n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to shift |
| amt_i | input | log2(WIDTH) | Unsigned shift amount |
| kind_i | input | 2 | 00 rotate, 01 logical, 10 arithmetic, 11 logical |
| dir_i | input | 1 | 0 left (toward MSB), 1 right (toward LSB) |
| data_o | output | WIDTH | Shifted result |

## Verification
The bench builds the block at its default WIDTH of 16, which makes the amount a 4-bit field. Because of this, every amount from 0 through 15 can be reached, including the width-minus-one boundary where only one original bit survives a plain shift. Directed vectors cover sign-set and sign-clear words in each mode. A long stream of random words, amounts, kinds and directions is then compared against a bit-loop model. The rotate identity between the two directions is checked on its own.

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [1:0]       kind_i,
  input  logic             dir_i,
  output logic [WIDTH-1:0] data_o
);

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    for (int i = 0; i < WIDTH; i++) flip[i] = v[WIDTH-1-i];
  endfunction

  logic             is_rot;
  logic             fill_bit;
  logic [WIDTH-1:0] stage [0:AMT_W];

  assign is_rot   = (kind_i == 2'b00);
  assign fill_bit = (kind_i == 2'b10) & dir_i & data_i[WIDTH-1];
  assign stage[0] = dir_i ? data_i : flip(data_i);

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] moved;
    assign moved = is_rot ? {stage[k][S-1:0], stage[k][WIDTH-1:S]}
                          : {{S{fill_bit}}, stage[k][WIDTH-1:S]};
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign data_o = dir_i ? stage[AMT_W] : flip(stage[AMT_W]);

  always_comb begin
    logic [WIDTH-1:0] low_mask;
    low_mask = (WIDTH'(1) << amt_i) - WIDTH'(1);
    if (!$isunknown({data_i, amt_i, kind_i, dir_i})) begin
      AST_ZERO_PASS: assert (amt_i != '0 || data_o == data_i)
        else $error("zero amount altered data"); // R8
      AST_ROT_KEEPS_ONES: assert (kind_i != 2'b00 || $countones(data_o) == $countones(data_i))
        else $error("rotate lost bits"); // R1
      AST_LEFT_LOW_ZERO: assert (kind_i == 2'b00 || dir_i || (data_o & low_mask) == '0)
        else $error("left shift fill not zero"); // R3
      AST_LSR_TOP_ZERO: assert (!(kind_i[0] && dir_i && amt_i != '0) || !data_o[WIDTH-1])
        else $error("logical right msb set"); // R4
      AST_ASR_SIGN_KEPT: assert (!(kind_i == 2'b10 && dir_i) || data_o[WIDTH-1] == data_i[WIDTH-1])
        else $error("arithmetic right lost sign"); // R5
    end
  end

endmodule

// File: tb/barrel_shift_unit_tb_top.sv
module barrel_shift_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [3:0]   amt_i = '0;
  logic [1:0]   kind_i = '0;
  logic         dir_i = 1'b0;
  logic [W-1:0] data_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  barrel_shift_unit #(.WIDTH(W)) dut_i (
    .data_i(data_i), .amt_i(amt_i), .kind_i(kind_i), .dir_i(dir_i), .data_o(data_o)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int n,
                                         input logic [1:0] k, input logic right);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int src;
      src = right ? i + n : i - n;
      if (src >= 0 && src < W) r[i] = d[src];
      else if (k == 2'b00) r[i] = d[(src + W) % W];
      else if (k == 2'b10 && right) r[i] = d[W-1];
      else r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [1:0] k, input logic right);
    if (a == 0) return "R8";
    if (a == 4'd15) return "R9";
    case (k)
      2'b00:   return right ? "R2" : "R1";
      2'b10:   return right ? "R5" : "R6";
      2'b11:   return "R7";
      default: return right ? "R4" : "R3";
    endcase
  endfunction

  task automatic check_vec(input logic [W-1:0] d, input logic [3:0] a,
                           input logic [1:0] k, input logic right,
                           input logic [W-1:0] exp, input string tag);
    @(posedge clk);
    #1;
    data_i = d; amt_i = a; kind_i = k; dir_i = right;
    @(negedge clk);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s d=%h amt=%0d kind=%b dir=%b got %h exp %h",
               tag, d, a, k, right, data_o, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] d, input logic [3:0] a,
                     input logic [1:0] k, input logic right);
    check_vec(d, a, k, right, model(d, int'(a), k, right), tag_of(a, k, right));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    check_vec('0, 4'd0, 2'b00, 1'b0, '0, "R8");
    check_vec(16'hED00, 4'd1, 2'b00, 1'b0, 16'hDA01, "R1");
    check_vec(16'h0001, 4'd1, 2'b00, 1'b1, 16'h8000, "R2");
    check_vec(16'hFFFF, 4'd4, 2'b01, 1'b0, 16'hFFF0, "R3");
    check_vec(16'hFFFF, 4'd4, 2'b01, 1'b1, 16'h0FFF, "R4");
    check_vec(16'hA000, 4'd2, 2'b10, 1'b1, 16'hE800, "R5");
    check_vec(16'h5000, 4'd2, 2'b10, 1'b1, 16'h1400, "R5");
    check_vec(16'h8001, 4'd3, 2'b10, 1'b0, 16'h0008, "R6");
    check_vec(16'h8F00, 4'd4, 2'b11, 1'b1, 16'h08F0, "R7");
    check_vec(16'h00F1, 4'd4, 2'b11, 1'b0, 16'h0F10, "R7");
    check_vec(16'h8000, 4'd15, 2'b10, 1'b1, 16'hFFFF, "R9");
    check_vec(16'h8000, 4'd15, 2'b01, 1'b1, 16'h0001, "R9");
    check_vec(16'h0003, 4'd15, 2'b00, 1'b0, 16'h8001, "R9");
    check_vec(16'h0003, 4'd15, 2'b01, 1'b0, 16'h8000, "R9");
    for (int k = 0; k < 4; k++)
      for (int dr = 0; dr < 2; dr++)
        check_vec(16'hC3A5, 4'd0, 2'(k), 1'(dr), 16'hC3A5, "R8");
    for (int n = 1; n < W; n++)
      check_vec(16'hB26D, 4'(n), 2'b00, 1'b1, model(16'hB26D, W - n, 2'b00, 1'b0), "R10");
    for (int i = 0; i < 3000; i++)
      run(W'($urandom), 4'($urandom), 2'($urandom), 1'($urandom));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule